// File: doc/BRIEF.md
# JTAG Scan Sequencer

This block is a JTAG host engine. It drives the TCK, TMS and TDI pins of a daisy chain of test access ports and samples the chain's TDO. A controller issues whole scan operations through a valid/ready command port. Three operations are available: return the chain to its idle state, load an instruction into one target device, or exchange a data register with that target. For each operation the engine produces the full TMS walk through the TAP state graph. It pads instruction scans so that every other device on the chain receives the all-ones BYPASS code, and it adds the single-bit bypass stages of the other devices around data scans.

TCK is a register clocked by the system clock, and its half period is set per command. TMS and TDI change while TCK falls. TDO is sampled as TCK rises. The bits captured during the payload window are returned on a parallel output together with a one-cycle completion pulse.

Top module: `jtag_scan_engine`

## Requirements
- R1: Operation code 00 (chain reset) produces 8 TCK cycles with TMS high and then one TCK cycle with TMS low. TDI stays low throughout.
- R2: Operation code 01 (instruction load) first produces TMS 1,1,0,0. It then shifts N = cmdPost + cmdLen + cmdPre bits, least significant first: cmdPost ones, then cmdData[0] to cmdData[cmdLen-1], then cmdPre ones. It ends with TMS 1,0.
- R3: Operation codes 10 and 11 (data scan) first produce TMS 1,0,0. They then shift cmdPost zeros, but only when cmdAdjust is 1, followed by cmdData[0] to cmdData[cmdLen-1] and then cmdPre zeros. They end with TMS 1,0. When cmdAdjust is 0, cmdPost has no effect on a data scan.
- R4: In both R2 and R3, TMS is high on the final shifted bit only. TDO is sampled at each rising TCK edge of the payload window, and the i-th payload sample appears in rxData[i]. Bits of rxData at or above cmdLen are 0.
- R5: TCK idles low. Each TCK cycle is a low half followed by a high half, and each half lasts divHalf+1 clk cycles. divHalf is taken at command acceptance, and later changes do not affect the running command.
- R6: Outside command acceptance, TMS and TDI change only in the clk cycle in which TCK falls. The first bit of each operation appears on the pins in the cycle after acceptance, while TCK is low.
- R7: cmdReady equals not busy. A command is accepted on a clk edge where cmdValid and cmdReady are both high, and busy rises in the following cycle. cmdValid asserted while busy has no effect, and cmdData, cmdLen, cmdPre, cmdPost and cmdOp may change freely after acceptance.
- R8: done is a one-cycle pulse in the cycle where busy falls, which follows the last falling TCK edge of the operation. rxData is updated in that same cycle and holds its value until the next done.
- R9: While rstN is low, tck, tms, tdi, busy, done and rxData are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divHalf | input | DIV_W | TCK half period minus one, in clk cycles |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine can accept a command |
| cmdOp | input | 2 | 00 reset, 01 instruction load, 1x data scan |
| cmdLen | input | clog2(MAX_LEN+1) | Target field length, 1 to MAX_LEN |
| cmdData | input | MAX_LEN | Payload, bit 0 shifted first |
| cmdPre | input | clog2(MAX_PAD+1) | Bypass bit count after the payload |
| cmdPost | input | clog2(MAX_PAD+1) | Bypass bit count before the payload |
| cmdAdjust | input | 1 | Data scan: shift cmdPost zeros before capturing |
| tck | output | 1 | Test clock pin |
| tms | output | 1 | Test mode select pin |
| tdi | output | 1 | Test data toward the chain |
| tdo | input | 1 | Test data from the chain |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse, rxData valid |
| rxData | output | MAX_LEN | Captured payload bits, first sample in bit 0 |

## Verification
The properties assume that cmdLen lies between 1 and MAX_LEN and that cmdPre and cmdPost do not exceed MAX_PAD at acceptance. The stimulus only offers commands inside those ranges. The properties do not assume cmdValid is idle during an operation. The stimulus deliberately raises it mid-scan, together with scrambled command fields and a new divider value, and releases it before the operation ends so that no second command is accepted. The stimulus drives TDO on falling clk edges. It changes TDO once at the start of each TCK cycle and inverts it just after the rising TCK edge, so a sample taken at any other moment picks up a wrong bit.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } seqState_t;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;     // command accepted: take payload and length
    logic drive;    // TCK falls now: present the next TDI bit
    logic useData;  // next bit comes from the payload
    logic fillBit;  // value of the next bit when not from the payload
    logic capture;  // TCK rises now inside the payload window
    logic finish;   // last falling edge: publish the received bits
  } dpStrobe_t;

endpackage

// File: rtl/jscan_ctrl.sv
module jscan_ctrl
  import jscan_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int MAX_PAD = 16,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int PAD_W  = $clog2(MAX_PAD + 1),
  localparam int CNT_W  = $clog2(MAX_LEN + 2 * MAX_PAD + 10)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic [PAD_W-1:0] cmdPre,
  input  logic [PAD_W-1:0] cmdPost,
  input  logic             cmdAdjust,
  output logic             cmdReady,
  output logic             tck,
  output logic             tms,
  output logic             busy,
  output logic             done,
  output dpStrobe_t        strobe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seqState_t        state, nState;
  logic             isResetQ, isIrQ;
  logic [CNT_W-1:0] winStartQ, winEndQ, totalQ, cnt, nCnt, leadLen, acceptStart;
  logic [DIV_W-1:0] divQ, phCnt;
  logic             tckQ, tmsQ, curInWin, doneQ;
  logic             nTms, nWin, lastStep, tickNow;
  logic [8:0]       leadPat, leadShifted;

  assign tickNow = (phCnt == divQ);

  // walk into Shift-IR / Shift-DR, or the forced reset walk
  always_comb begin
    if (isResetQ) begin
      leadLen = CNT_W'(9);
      leadPat = 9'b0_1111_1111;
    end else if (isIrQ) begin
      leadLen = CNT_W'(4);
      leadPat = 9'b0_0000_0011;
    end else begin
      leadLen = CNT_W'(3);
      leadPat = 9'b0_0000_0001;
    end
  end

  assign acceptStart = (cmdOp == 2'b01 || (cmdOp[1] && cmdAdjust)) ? CNT_W'(cmdPost) : '0;

  // the TCK cycle that follows the current one
  always_comb begin
    nState      = state;
    nCnt        = cnt + ONE;
    nTms        = 1'b0;
    nWin        = 1'b0;
    lastStep    = 1'b0;
    leadShifted = leadPat >> nCnt;
    case (state)
      ST_LEAD: begin
        if (nCnt < leadLen) begin
          nTms = leadShifted[0];
        end else if (isResetQ) begin
          lastStep = 1'b1;
        end else begin
          nState = ST_SHIFT;
          nCnt   = '0;
          nTms   = (totalQ == ONE);
          nWin   = (winStartQ == '0);
        end
      end
      ST_SHIFT: begin
        if (nCnt < totalQ) begin
          nTms = (nCnt + ONE == totalQ);
          nWin = (nCnt >= winStartQ) && (nCnt < winEndQ);
        end else begin
          nState = ST_TAIL;
          nCnt   = '0;
          nTms   = 1'b1;
        end
      end
      ST_TAIL: begin
        if (cnt != '0) lastStep = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isResetQ  <= 1'b0;
      isIrQ     <= 1'b0;
      winStartQ <= '0;
      winEndQ   <= '0;
      totalQ    <= '0;
      cnt       <= '0;
      divQ      <= '0;
      phCnt     <= '0;
      tckQ      <= 1'b0;
      tmsQ      <= 1'b0;
      curInWin  <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (state == ST_IDLE) begin
        if (cmdValid) begin
          state     <= ST_LEAD;
          isResetQ  <= (cmdOp == 2'b00);
          isIrQ     <= (cmdOp == 2'b01);
          winStartQ <= acceptStart;
          winEndQ   <= acceptStart + CNT_W'(cmdLen);
          totalQ    <= acceptStart + CNT_W'(cmdLen) + CNT_W'(cmdPre);
          cnt       <= '0;
          divQ      <= divHalf;
          phCnt     <= '0;
          tckQ      <= 1'b0;
          tmsQ      <= 1'b1;
          curInWin  <= 1'b0;
        end
      end else if (!tickNow) begin
        phCnt <= phCnt + DIV_W'(1);
      end else begin
        phCnt <= '0;
        if (!tckQ) begin
          tckQ <= 1'b1;
        end else begin
          tckQ <= 1'b0;
          if (lastStep) begin
            state    <= ST_IDLE;
            tmsQ     <= 1'b0;
            curInWin <= 1'b0;
            doneQ    <= 1'b1;
          end else begin
            state    <= nState;
            cnt      <= nCnt;
            tmsQ     <= nTms;
            curInWin <= nWin;
          end
        end
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign cmdReady = (state == ST_IDLE);
  assign tck      = tckQ;
  assign tms      = tmsQ;
  assign done     = doneQ;

  always_comb begin
    strobe.load    = (state == ST_IDLE) && cmdValid;
    strobe.drive   = busy && tickNow && tckQ;
    strobe.useData = nWin && !lastStep;
    strobe.fillBit = isIrQ && (nState == ST_SHIFT) && !lastStep;
    strobe.capture = busy && tickNow && !tckQ && curInWin;
    strobe.finish  = busy && tickNow && tckQ && lastStep;
  end

endmodule

// File: rtl/jscan_dp.sv
module jscan_dp
  import jscan_pkg::*;
#(
  parameter int MAX_LEN = 64,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [MAX_LEN-1:0] cmdData,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic               tdo,
  output logic               tdi,
  output logic [MAX_LEN-1:0] rxData
);

  logic [MAX_LEN-1:0] txShift, rxShift;
  logic [LEN_W-1:0]   lenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      lenQ    <= '0;
      tdi     <= 1'b0;
      rxData  <= '0;
    end else begin
      if (strobe.load) begin
        txShift <= cmdData;
        rxShift <= '0;
        lenQ    <= cmdLen;
        tdi     <= 1'b0;
      end
      if (strobe.capture) rxShift <= {tdo, rxShift[MAX_LEN-1:1]};
      if (strobe.drive) begin
        if (strobe.useData) begin
          tdi     <= txShift[0];
          txShift <= txShift >> 1;
        end else begin
          tdi <= strobe.fillBit;
        end
      end
      if (strobe.finish) rxData <= rxShift >> (LEN_W'(MAX_LEN) - lenQ);
    end
  end

endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
  import jscan_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int MAX_PAD = 16,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int PAD_W  = $clog2(MAX_PAD + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DIV_W-1:0]   divHalf,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [1:0]         cmdOp,
  input  logic [LEN_W-1:0]   cmdLen,
  input  logic [MAX_LEN-1:0] cmdData,
  input  logic [PAD_W-1:0]   cmdPre,
  input  logic [PAD_W-1:0]   cmdPost,
  input  logic               cmdAdjust,
  output logic               tck,
  output logic               tms,
  output logic               tdi,
  input  logic               tdo,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] rxData
);

  dpStrobe_t strobe;

  jscan_ctrl #(.MAX_LEN(MAX_LEN), .MAX_PAD(MAX_PAD), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .divHalf(divHalf), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdLen(cmdLen), .cmdPre(cmdPre), .cmdPost(cmdPost), .cmdAdjust(cmdAdjust),
    .cmdReady(cmdReady), .tck(tck), .tms(tms), .busy(busy), .done(done), .strobe(strobe)
  );

  jscan_dp #(.MAX_LEN(MAX_LEN)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdData(cmdData), .cmdLen(cmdLen),
    .tdo(tdo), .tdi(tdi), .rxData(rxData)
  );

endmodule

// File: rtl/jscan_checker.sv
module jscan_checker #(
  parameter int MAX_LEN = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic               tck,
  input logic               tms,
  input logic               tdi,
  input logic               busy,
  input logic               done,
  input logic [MAX_LEN-1:0] rxData
);

  // R6: pins move only when TCK falls while an operation runs
  assert_pins_on_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy && !$fell(tck)) |-> ($stable(tms) && $stable(tdi)));

  // R5: TCK rests low between operations
  assert_tck_idle_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck);

  // R7: an operation starts only from an accepted command
  assert_start_on_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid && cmdReady));

  // R8: completion is a single pulse at the end of busy
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rxData));

endmodule

bind jtag_scan_engine jscan_checker #(.MAX_LEN(MAX_LEN)) uChecker (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .tck(tck),
  .tms(tms), .tdi(tdi), .busy(busy), .done(done), .rxData(rxData)
);

// File: tb/tb_jtag_scan_engine.sv
module tb_jtag_scan_engine;

  localparam int MAX_LEN = 64;
  localparam int MAX_PAD = 16;
  localparam int DIV_W   = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [DIV_W-1:0]   divHalf = '0;
  logic               cmdValid = 1'b0;
  logic               cmdReady;
  logic [1:0]         cmdOp = '0;
  logic [6:0]         cmdLen = '0;
  logic [MAX_LEN-1:0] cmdData = '0;
  logic [4:0]         cmdPre = '0;
  logic [4:0]         cmdPost = '0;
  logic               cmdAdjust = 1'b0;
  logic               tck, tms, tdi, busy, done;
  logic               tdo = 1'b0;
  logic [MAX_LEN-1:0] rxData;

  int checks = 0;
  int errors = 0;

  bit stepTms[$];
  bit stepTdi[$];
  bit stepWin[$];
  logic [255:0] tdoPat;

  always #2 clk = ~clk;

  jtag_scan_engine #(.MAX_LEN(MAX_LEN), .MAX_PAD(MAX_PAD), .DIV_W(DIV_W)) dut (
    .clk(clk), .rstN(rstN), .divHalf(divHalf), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdLen(cmdLen), .cmdData(cmdData), .cmdPre(cmdPre), .cmdPost(cmdPost),
    .cmdAdjust(cmdAdjust), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .busy(busy),
    .done(done), .rxData(rxData)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic addStep(bit m, bit d, bit w);
    stepTms.push_back(m);
    stepTdi.push_back(d);
    stepWin.push_back(w);
  endtask

  // behavioural list of TCK cycles for one operation
  task automatic buildSteps(int op, int len, logic [63:0] data, int pre, int post, bit adj);
    int ws, n;
    stepTms.delete(); stepTdi.delete(); stepWin.delete();
    if (op == 0) begin
      for (int i = 0; i < 8; i++) addStep(1, 0, 0);
      addStep(0, 0, 0);
    end else begin
      if (op == 1) begin
        addStep(1, 0, 0); addStep(1, 0, 0); addStep(0, 0, 0); addStep(0, 0, 0);
      end else begin
        addStep(1, 0, 0); addStep(0, 0, 0); addStep(0, 0, 0);
      end
      ws = (op == 1 || adj) ? post : 0;
      n  = ws + len + pre;
      for (int i = 0; i < n; i++) begin
        bit inWin;
        inWin = (i >= ws) && (i < ws + len);
        addStep(i == n - 1, inWin ? data[i - ws] : (op == 1), inWin);
      end
      addStep(1, 0, 0); addStep(0, 0, 0);
    end
  endtask

  task automatic runCmd(int op, int len, logic [63:0] data, int pre, int post, bit adj,
                        int div, bit intrude);
    int h, s, total, wi;
    string opTag;
    logic [63:0] expRx;
    opTag = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
    buildSteps(op, len, data, pre, post, adj);
    s = stepTms.size();
    h = div + 1;
    total = 2 * h * s;
    for (int i = 0; i < 4; i++) tdoPat[i*64 +: 64] = {$urandom, $urandom};
    @(negedge clk);
    chk("R7", "ready before accept", {63'd0, cmdReady}, 64'd1);
    cmdOp = 2'(op); cmdLen = 7'(len); cmdData = data; cmdPre = 5'(pre);
    cmdPost = 5'(post); cmdAdjust = adj; divHalf = DIV_W'(div); cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdData = ~data; cmdLen = 7'(len ^ 5); cmdPre = ~cmdPre; cmdPost = ~cmdPost;
    cmdAdjust = ~adj; divHalf = DIV_W'(div + 3);
    expRx = '0;
    wi = 0;
    for (int j = 0; j <= total; j++) begin
      if (j < total) begin
        int st, k;
        st = j / (2 * h);
        k  = j % (2 * h);
        if (k == 0) begin
          tdo = tdoPat[st];
          if (stepWin[st]) begin
            expRx[wi] = tdoPat[st];
            wi++;
          end
        end
        if (k == h) tdo = ~tdoPat[st];
        if (intrude && j == 3) begin cmdValid = 1'b1; cmdOp = 2'b00; end
        if (intrude && j == 6) cmdValid = 1'b0;
        chk(opTag, "tms,tdi", {62'd0, tms, tdi}, {62'd0, stepTms[st], stepTdi[st]});
        chk("R5", "tck", {63'd0, tck}, {63'd0, (k >= h)});
        chk("R7", "busy,ready", {62'd0, busy, cmdReady}, 64'd2);
        chk("R8", "done early", {63'd0, done}, 64'd0);
      end else begin
        chk("R8", "done,busy at end", {62'd0, done, busy}, 64'd2);
        chk("R6", "pins at end", {61'd0, tck, tms, tdi}, 64'd0);
        chk("R4", "rxData", rxData, expRx);
      end
      @(negedge clk);
    end
    chk("R8", "done drops", {63'd0, done}, 64'd0);
    chk("R8", "rxData held", rxData, expRx);
    chk("R7", "ready after", {62'd0, busy, cmdReady}, 64'd1);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9", "pins in reset", {61'd0, tck, tms, tdi}, 64'd0);
    chk("R9", "busy,done in reset", {62'd0, busy, done}, 64'd0);
    chk("R9", "rxData in reset", rxData, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCmd(0, 1, 64'd0, 0, 0, 0, 0, 0);                        // R1
    runCmd(1, 4, 64'h8, 3, 2, 0, 0, 0);                        // R2 padded
    runCmd(1, 4, 64'h2, 0, 0, 1, 1, 0);                        // R2 lone device, R5 div
    runCmd(2, 32, 64'hDEAD_BEEF, 2, 3, 1, 0, 0);               // R3 with adjust
    runCmd(3, 8, 64'hA5, 0, 5, 0, 2, 1);                       // R3 post ignored, R7 intrude
    runCmd(2, 64, 64'h0123_4567_89AB_CDEF, 16, 16, 1, 0, 0);   // R4 full width
    runCmd(2, 1, 64'h1, 0, 0, 0, 0, 0);                        // R4 single bit
    runCmd(0, 1, 64'd0, 0, 0, 0, 1, 1);                        // R1 slow, R7 intrude

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule